// File: doc/BRIEF.md
# Paired While-Lower Predicate Generator

This unit builds the two predicate register images that a vector loop uses to switch off the lanes past its trip count. It takes a 64-bit unsigned start value, a 64-bit unsigned limit and a lane-size code. Lane e of the combined pair, counted from lane 0 of the low image, is active while start + e is below the limit. Once one lane fails the test, that lane and every lane above it stay inactive. The vector length is a parameter (a multiple of 128 from 128 to 2048 bits). Each image holds one bit per byte of the vector.

The caller presents the operands together with a one-cycle start strobe. One clock later the unit shows the low image, the high image and four condition flags, and it raises `done_o` for one cycle. The outputs then hold until the next strobe. A synchronous active-high reset clears them. The unit does not need a chain of 64-bit adders. It computes how many lanes are active as `min(limit - start, lanes in pair)` when start < limit and 0 otherwise. It then spreads that count over the predicate bits for the selected lane size.

Top module: `pair_pred_gen`

## Requirements
- R1: Lane-size code 0, 1, 2 and 3 selects 8-, 16-, 32- and 64-bit lanes. A lane covers 1, 2, 4 or 8 predicate bits. Only the lowest bit of each lane may be 1, and the other bits of the lane are always 0.
- R2: Lane e is active exactly when start + e < limit. The comparison is unsigned and uses all 64 bits of both operands, for every lane size.
- R3: Once a lane is inactive, every higher lane is inactive. If start >= limit, both images are all zero, including when start + e would wrap past 2^64 - 1.
- R4: The pair holds (VL/4) >> code lanes. The low image carries predicate bits 0 to VL/8-1 of the pair, and the high image carries the bits above them.
- R5: `flag_n_o` equals the value of lane 0.
- R6: `flag_z_o` is 1 exactly when no lane of the pair is active.
- R7: `flag_c_o` is the inverse of the value of the highest lane of the pair.
- R8: `flag_v_o` is always 0.
- R9: `done_o` pulses high in the cycle after `start_i`. The images and flags change only in that cycle and hold while no strobe arrives, whatever the operand inputs do.
- R10: While `rst` is high at a clock edge, the outputs and `done_o` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Strobe that captures the operands |
| base_i | input | 64 | Unsigned start value |
| bound_i | input | 64 | Unsigned limit |
| lane_size_i | input | 2 | Lane-size code |
| done_o | output | 1 | Result-valid pulse |
| pred_lo_o | output | VL_BITS/8 | Low predicate image |
| pred_hi_o | output | VL_BITS/8 | High predicate image |
| flag_n_o | output | 1 | Lane 0 active |
| flag_z_o | output | 1 | No lane active |
| flag_c_o | output | 1 | Highest lane inactive |
| flag_v_o | output | 1 | Always 0 |

## Verification
The assertions assume that reset is applied before the first strobe. They also assume that the operands and the lane-size code are stable at the clock edge where `start_i` is high, because the properties on the empty result and on lane 0 read those inputs at the strobe edge. The bench changes every input only on falling clock edges. Between strobes it deliberately changes the operands at random to exercise the hold behaviour. It uses start values near 2^64 and limits that differ only above bit 32 to reach the wrap and full-width cases.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

    localparam int unsigned SCALAR_W = 64;

    typedef enum logic [1:0] {
        LANE_B8  = 2'b00,
        LANE_H16 = 2'b01,
        LANE_W32 = 2'b10,
        LANE_D64 = 2'b11
    } lane_size_e;

    typedef struct packed {
        logic [SCALAR_W-1:0] base;
        logic [SCALAR_W-1:0] bound;
        lane_size_e          lsz;
    } span_req_t;

    typedef struct packed {
        logic first;
        logic none;
        logic not_last;
        logic ovf;
    } pred_flags_t;

    // lanes of the whole pair for a pair width counted in bytes
    function automatic int unsigned lanes_in_pair(int unsigned pair_w, lane_size_e lsz);
        return pair_w >> int'(lsz);
    endfunction

endpackage

// File: rtl/pg_span_count.sv
module pg_span_count
    import lpg_pkg::*;
#(
    parameter int unsigned PAIR_W = 64,
    parameter int unsigned CNT_W  = 7
) (
    input  span_req_t        req,
    output logic [CNT_W-1:0] active_cnt,
    output logic [CNT_W-1:0] lane_total
);
    logic [SCALAR_W-1:0] gap;
    logic [SCALAR_W-1:0] total_wide;
    logic                in_range;

    always_comb begin
        lane_total = CNT_W'(lanes_in_pair(PAIR_W, req.lsz));
        total_wide = SCALAR_W'(lane_total);
        in_range   = req.base < req.bound;
        gap        = req.bound - req.base;
        if (!in_range) begin
            active_cnt = '0;
        end else if (gap >= total_wide) begin
            active_cnt = lane_total;
        end else begin
            active_cnt = gap[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/pg_pred_expand.sv
module pg_pred_expand
    import lpg_pkg::*;
#(
    parameter int unsigned PAIR_W = 64,
    parameter int unsigned CNT_W  = 7
) (
    input  logic [CNT_W-1:0]  active_cnt,
    input  lane_size_e        lsz,
    output logic [PAIR_W-1:0] pair_bits
);
    logic [1:0] sel;
    assign sel = lsz;

    for (genvar i = 0; i < PAIR_W; i++) begin : g_bit
        logic [3:0] hit;
        for (genvar s = 0; s < 4; s++) begin : g_sz
            localparam int unsigned LANE = i >> s;
            if ((i % (1 << s)) == 0) begin : g_head
                assign hit[s] = active_cnt > CNT_W'(LANE);
            end else begin : g_pad
                assign hit[s] = 1'b0;
            end
        end
        assign pair_bits[i] = hit[sel];
    end
endmodule

// File: rtl/pg_flag_eval.sv
module pg_flag_eval
    import lpg_pkg::*;
#(
    parameter int unsigned CNT_W = 7
) (
    input  logic [CNT_W-1:0] active_cnt,
    input  logic [CNT_W-1:0] lane_total,
    output pred_flags_t      flags
);
    always_comb begin
        flags.first    = active_cnt != '0;
        flags.none     = active_cnt == '0;
        flags.not_last = active_cnt != lane_total;
        flags.ovf      = 1'b0;
    end
endmodule

// File: rtl/pair_pred_gen.sv
module pair_pred_gen
    import lpg_pkg::*;
#(
    parameter int unsigned VL_BITS = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [63:0]          base_i,
    input  logic [63:0]          bound_i,
    input  logic [1:0]           lane_size_i,
    output logic                 done_o,
    output logic [VL_BITS/8-1:0] pred_lo_o,
    output logic [VL_BITS/8-1:0] pred_hi_o,
    output logic                 flag_n_o,
    output logic                 flag_z_o,
    output logic                 flag_c_o,
    output logic                 flag_v_o
);
    localparam int unsigned PRED_W = VL_BITS / 8;
    localparam int unsigned PAIR_W = 2 * PRED_W;
    localparam int unsigned CNT_W  = $clog2(PAIR_W + 1);
    localparam int unsigned IDX_W  = $clog2(PAIR_W);

    span_req_t         req;
    logic [CNT_W-1:0]  active_cnt;
    logic [CNT_W-1:0]  lane_total;
    logic [PAIR_W-1:0] pair_d;
    pred_flags_t       flags_d;

    logic [PAIR_W-1:0] pair_q;
    pred_flags_t       flags_q;
    lane_size_e        lsz_q;
    logic              done_q;

    assign req.base  = base_i;
    assign req.bound = bound_i;
    assign req.lsz   = lane_size_e'(lane_size_i);

    pg_span_count #(.PAIR_W(PAIR_W), .CNT_W(CNT_W)) u_count (
        .req        (req),
        .active_cnt (active_cnt),
        .lane_total (lane_total)
    );

    pg_pred_expand #(.PAIR_W(PAIR_W), .CNT_W(CNT_W)) u_expand (
        .active_cnt (active_cnt),
        .lsz        (req.lsz),
        .pair_bits  (pair_d)
    );

    pg_flag_eval #(.CNT_W(CNT_W)) u_flags (
        .active_cnt (active_cnt),
        .lane_total (lane_total),
        .flags      (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q  <= '0;
            flags_q <= '0;
            lsz_q   <= LANE_B8;
            done_q  <= 1'b0;
        end else begin
            done_q <= start_i;
            if (start_i) begin
                pair_q  <= pair_d;
                flags_q <= flags_d;
                lsz_q   <= req.lsz;
            end
        end
    end

    assign done_o    = done_q;
    assign pred_lo_o = pair_q[PRED_W-1:0];
    assign pred_hi_o = pair_q[PAIR_W-1:PRED_W];
    assign flag_n_o  = flags_q.first;
    assign flag_z_o  = flags_q.none;
    assign flag_c_o  = flags_q.not_last;
    assign flag_v_o  = flags_q.ovf;

    // bit position of the highest lane of the pair for the captured size
    logic [IDX_W-1:0] last_idx;
    assign last_idx = IDX_W'(PAIR_W - (32'd1 << int'(lsz_q)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        start_i |=> done_o);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !start_i |=> (!done_o && $stable(pred_lo_o) && $stable(pred_hi_o)));

    p_empty_r3: assert property (@(posedge clk) disable iff (rst)
        (start_i && (base_i >= bound_i)) |=> (pred_lo_o == '0 && pred_hi_o == '0));

    p_first_lane_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && (base_i < bound_i)) |=> pred_lo_o[0]);

    p_n_flag_r5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (flag_n_o == pred_lo_o[0]));

    p_z_flag_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (flag_z_o == ((pred_lo_o | pred_hi_o) == '0)));

    p_c_flag_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (flag_c_o == !pair_q[last_idx]));
endmodule

// File: tb/pair_pred_gen_tb_top.sv
module pair_pred_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] base = '0;
    logic [63:0] bound = '0;
    logic [1:0]  lsz = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit live_cmp = 0;

    always #4 clk = ~clk;

    logic        done_a, done_b;
    logic [31:0] lo_a, hi_a;
    logic [63:0] lo_b, hi_b;
    logic [3:0]  fl_a, fl_b;

    pair_pred_gen #(.VL_BITS(256)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .base_i(base), .bound_i(bound),
        .lane_size_i(lsz), .done_o(done_a), .pred_lo_o(lo_a), .pred_hi_o(hi_a),
        .flag_n_o(fl_a[3]), .flag_z_o(fl_a[2]), .flag_c_o(fl_a[1]), .flag_v_o(fl_a[0])
    );

    pair_pred_gen #(.VL_BITS(512)) dut_w (
        .clk(clk), .rst(rst), .start_i(start), .base_i(base), .bound_i(bound),
        .lane_size_i(lsz), .done_o(done_b), .pred_lo_o(lo_b), .pred_hi_o(hi_b),
        .flag_n_o(fl_b[3]), .flag_z_o(fl_b[2]), .flag_c_o(fl_b[1]), .flag_v_o(fl_b[0])
    );

    // sequential lane-by-lane reference: counter walks upward, sticky live flag
    task automatic ref_calc(input int vl, input logic [63:0] b, input logic [63:0] l,
                            input logic [1:0] s, output logic [63:0] lo,
                            output logic [63:0] hi, output logic [3:0] fl);
        int pw;
        int lanes;
        int step;
        logic [127:0] all;
        logic [63:0]  cur;
        bit live;
        bit any;
        pw = vl / 8; lanes = (2 * pw) >> s; step = 1 << s;
        all = '0; cur = b; live = 1; any = 0; fl = '0;
        for (int e = 0; e < lanes; e++) begin
            live = live && (cur < l);
            if (live) begin all[e*step] = 1'b1; any = 1; end
            if (e == 0) fl[3] = live;
            cur = cur + 64'd1;
        end
        fl[2] = !any; fl[1] = !live; fl[0] = 1'b0;
        lo = '0; hi = '0;
        for (int i = 0; i < pw; i++) begin
            lo[i] = all[i];
            hi[i] = all[pw+i];
        end
    endtask

    // expected registered state, updated at the same edge as the design
    logic [63:0] e_lo [2];
    logic [63:0] e_hi [2];
    logic [3:0]  e_fl [2];
    logic        e_done;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 2; k++) begin e_lo[k] = '0; e_hi[k] = '0; e_fl[k] = '0; end
            e_done = 1'b0;
        end else begin
            e_done = start;
            if (start) begin
                ref_calc(256, base, bound, lsz, e_lo[0], e_hi[0], e_fl[0]);
                ref_calc(512, base, bound, lsz, e_lo[1], e_hi[1], e_fl[1]);
            end
        end
        live_cmp = 1;
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tp, input string tf, input string td);
        chk(tp, "lo256", {32'd0, lo_a}, e_lo[0]);
        chk(tp, "hi256", {32'd0, hi_a}, e_hi[0]);
        chk(tp, "lo512", lo_b, e_lo[1]);
        chk(tp, "hi512", hi_b, e_hi[1]);
        chk(tf, "flags256", {60'd0, fl_a}, {60'd0, e_fl[0]});
        chk(tf, "flags512", {60'd0, fl_b}, {60'd0, e_fl[1]});
        chk(td, "done256", {63'd0, done_a}, {63'd0, e_done});
        chk(td, "done512", {63'd0, done_b}, {63'd0, e_done});
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (live_cmp) begin
            if (rst) compare_all("R10", "R10", "R10");
            else     compare_all("R2,R4", "R5,R6,R7,R8", "R9");
        end
    end

    task automatic issue(input logic [63:0] b, input logic [63:0] l, input logic [1:0] s,
                         input string tag);
        logic [63:0] lo, hi;
        logic [3:0]  fl;
        @(negedge clk);
        base = b; bound = l; lsz = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ref_calc(256, b, l, s, lo, hi, fl);
        chk(tag, "pair256", {lo_a, hi_a}, {lo[31:0], hi[31:0]});
        chk(tag, "fl256", {60'd0, fl_a}, {60'd0, fl});
        ref_calc(512, b, l, s, lo, hi, fl);
        chk(tag, "lo512", lo_b, lo);
        chk(tag, "hi512", hi_b, hi);
        chk(tag, "fl512", {60'd0, fl_b}, {60'd0, fl});
    endtask

    task automatic idle_scramble(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            base = {$urandom, $urandom}; bound = {$urandom, $urandom}; lsz = 2'($urandom);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset_lo", {32'd0, lo_a}, 64'd0);
        chk("R10", "reset_done", {63'd0, done_a}, 64'd0);
        rst = 1'b0;

        issue(64'd10, 64'd20, 2'd0, "R2");
        issue(64'd0, 64'd40, 2'd0, "R4");
        issue(64'd0, 64'd40, 2'd1, "R4");
        issue(64'd5, 64'd6, 2'd3, "R1");
        issue(64'd3, 64'd9, 2'd2, "R1");
        issue(64'd100, 64'd100, 2'd0, "R6");
        issue(64'd101, 64'd100, 2'd2, "R3");
        issue(64'hFFFF_FFFF_FFFF_FFFE, 64'd3, 2'd0, "R3");
        issue(64'hFFFF_FFFF_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, "R3");
        issue(64'h0000_0100_0000_0000, 64'h0000_0100_0000_0003, 2'd0, "R2");
        issue(64'h0000_0001_0000_0005, 64'h0000_0000_0000_0009, 2'd0, "R2");
        issue(64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, "R7");
        issue(64'd7, 64'h0000_0100_0000_0007, 2'd3, "R7");
        issue(64'd50, 64'd51, 2'd0, "R5");
        issue(64'd0, 64'd8, 2'd3, "R8");
        idle_scramble(5);
        issue(64'd4, 64'd8, 2'd0, "R9");
        idle_scramble(6);

        for (int t = 0; t < 120; t++) begin
            logic [63:0] b;
            logic [63:0] g;
            b = (t % 3 == 0) ? {$urandom, $urandom} : 64'($urandom % 1000);
            g = 64'($urandom % 140);
            issue(b, b + g, 2'($urandom), "R2");
            if (t % 4 == 0) idle_scramble(2);
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "reset_hi512", hi_b, 64'd0);
        chk("R10", "reset_flags", {60'd0, fl_b}, 64'd0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule